// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This engine moves a requested number of bytes between a byte stream on the device side and a set of memory regions. The regions are listed in a table of descriptors in memory. After a start pulse the engine reads descriptors from the table base, one at a time, and splits the transfer over the regions they describe. With the direction input set, it takes bytes from the inbound stream and writes them to memory. With the direction input clear, it reads memory and sends the bytes out on the outbound stream.

All memory traffic goes through one 32-bit word port with a request/acknowledge handshake. Only one access is in flight at a time. Bytes that do not fill a whole word are written with byte enables. A run ends in one of two ways. A one-cycle done pulse means the request was fully served. A one-cycle exhausted pulse means the table ran out first, either through a last-entry flag or because the walk reached the 4 KiB window above the base.

Top module: `sg_dma_engine`

## Requirements
- R1: A descriptor is two little-endian 32-bit words. The word at table offset +0 is the region start address and the word at +4 is the size/flags word. Memory byte address A maps to bits 7:0 of the word read at A. The table pointer moves up by 8 after each descriptor. The table base is used with its two low bits cleared.
- R2: A region's byte count is size-word bits 15:1 followed by a zero bit, so size-word bit 0 has no effect on the number of bytes moved.
- R3: A count field (size-word bits 15:1) of zero means a region of 65536 bytes.
- R4: Size-word bit 31 flags the final descriptor. Once that region is used up with bytes still owed, no further descriptor is read and the run ends with exhausted.
- R5: A descriptor is read only when the current region has zero bytes left. Each piece moved is the smaller of the bytes still owed and the bytes left in the region, and the region address and count advance by that amount.
- R6: No descriptor is read once the table pointer is 4096 or more bytes above the base. A run still owing bytes at that point ends with exhausted.
- R7: done pulses for exactly one cycle when the owed count reaches zero. A request of zero bytes ends with done and no memory access.
- R8: With to_mem high, inbound bytes are written in order to the region bytes, and no other memory byte changes. With to_mem low, region bytes are sent out in address order. The two stream directions are never active together.
- R9: Every memory access uses a word-aligned address. A write never has an empty byte-enable mask. mem_req, with its address, direction, enables and write data, holds steady until mem_ack.
- R10: A start accepted while idle reloads the table pointer from the base and clears the region state. A start after an exhausted run therefore walks the table again from its first entry.
- R11: busy is high from an accepted start until the outcome pulse. While idle, the memory request and both stream handshakes stay low. done and exhausted are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken while idle) |
| tbl_base | input | 32 | Descriptor table base address |
| xfer_len | input | LEN_W | Bytes to move |
| to_mem | input | 1 | 1: stream to memory, 0: memory to stream |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: request fully served |
| exhausted | output | 1 | One-cycle pulse: table ran out first |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| in_valid | input | 1 | Inbound byte available |
| in_data | input | 8 | Inbound byte |
| in_ready | output | 1 | Engine takes the inbound byte |
| out_valid | output | 1 | Outbound byte available |
| out_data | output | 8 | Outbound byte |
| out_ready | input | 1 | Consumer takes the outbound byte |

## Verification
The hold property on the memory port assumes the memory raises mem_ack only while mem_req is high, for one cycle per access, and returns read data with that acknowledge. The bench memory answers only a request that is not already acknowledged, after a random delay, and drops the acknowledge on the next cycle. The stream properties assume the producer and consumer follow valid/ready. The bench changes in_valid, in_data and out_ready only at the falling edge and counts a byte only when both sides of its handshake are high. The bench places region addresses away from the table, so the writes of a run never change descriptors it has not yet read.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

    localparam int unsigned WORD_BYTES  = 4;
    localparam int unsigned DESC_STRIDE = 8;
    localparam int unsigned REGION_W    = 17;   // holds 1..65536

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_EVAL   = 3'd1,
        ST_DESC_A = 3'd2,
        ST_DESC_S = 3'd3,
        ST_GATHER = 3'd4,
        ST_WRITE  = 3'd5,
        ST_READ   = 3'd6,
        ST_EMIT   = 3'd7
    } sgd_state_e;

endpackage

// File: rtl/sgd_desc_decode.sv
module sgd_desc_decode
    import sgd_pkg::*;
(
    input  logic [31:0]         size_word,
    output logic [REGION_W-1:0] region_len,
    output logic                final_flag
);
    logic unused_size_bits;
    assign unused_size_bits = ^{size_word[30:16], size_word[0]};

    always_comb begin
        if (size_word[15:1] == '0) begin
            region_len = REGION_W'(1 << 16);
        end else begin
            region_len = REGION_W'({size_word[15:1], 1'b0});
        end
    end

    assign final_flag = size_word[31];
endmodule

// File: rtl/sgd_chunk_sizer.sv
module sgd_chunk_sizer
    import sgd_pkg::*;
#(
    parameter int unsigned LEN_W = 20,
    parameter int unsigned LANES = 4,
    localparam int unsigned OFF_W = $clog2(LANES),
    localparam int unsigned N_W   = OFF_W + 1
) (
    input  logic [LEN_W-1:0]    owed,
    input  logic [REGION_W-1:0] left,
    input  logic [OFF_W-1:0]    offset,
    output logic [N_W-1:0]      nbytes
);
    always_comb begin
        nbytes = N_W'(LANES) - N_W'(offset);
        if (owed < LEN_W'(nbytes)) begin
            nbytes = N_W'(owed);
        end
        if (left < REGION_W'(nbytes)) begin
            nbytes = N_W'(left);
        end
    end
endmodule

// File: rtl/sgd_lane_mask.sv
module sgd_lane_mask #(
    parameter int unsigned LANES = 4,
    localparam int unsigned OFF_W = $clog2(LANES),
    localparam int unsigned N_W   = OFF_W + 1
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [N_W-1:0]   nbytes,
    output logic [LANES-1:0] enables
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign enables[i] = ((N_W+1)'(i) >= (N_W+1)'(offset)) &&
                            ((N_W+1)'(i) < ((N_W+1)'(offset) + (N_W+1)'(nbytes)));
    end
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
    import sgd_pkg::*;
#(
    parameter int unsigned LEN_W      = 20,
    parameter int unsigned PAGE_BYTES = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      tbl_base,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic             to_mem,
    output logic             busy,
    output logic             done,
    output logic             exhausted,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    input  logic             out_ready
);
    localparam int unsigned LANES = WORD_BYTES;
    localparam int unsigned OFF_W = $clog2(LANES);
    localparam int unsigned N_W   = OFF_W + 1;

    typedef struct packed {
        sgd_state_e          st;
        logic [31:0]         base;
        logic [31:0]         tp;
        logic [31:0]         raddr;
        logic [LEN_W-1:0]    owed;
        logic [REGION_W-1:0] rleft;
        logic                fin;
        logic                dir_mem;
        logic [N_W-1:0]      n;
        logic [N_W-1:0]      k;
        logic [31:0]         data;
        logic                done;
        logic                exh;
    } regs_t;

    regs_t r_d, r_q;

    logic [REGION_W-1:0] dec_len;
    logic                dec_fin;
    logic [N_W-1:0]      chunk_n;
    logic [LANES-1:0]    lane_be;
    logic [OFF_W-1:0]    lane;
    logic                page_out;
    logic [31:0]         word_addr;

    sgd_desc_decode u_decode (
        .size_word  (mem_rdata),
        .region_len (dec_len),
        .final_flag (dec_fin)
    );

    sgd_chunk_sizer #(.LEN_W(LEN_W), .LANES(LANES)) u_sizer (
        .owed   (r_q.owed),
        .left   (r_q.rleft),
        .offset (r_q.raddr[OFF_W-1:0]),
        .nbytes (chunk_n)
    );

    sgd_lane_mask #(.LANES(LANES)) u_mask (
        .offset  (r_q.raddr[OFF_W-1:0]),
        .nbytes  (r_q.n),
        .enables (lane_be)
    );

    assign lane      = r_q.raddr[OFF_W-1:0] + r_q.k[OFF_W-1:0];
    assign page_out  = (r_q.tp - r_q.base) >= 32'(PAGE_BYTES);
    assign word_addr = {r_q.raddr[31:OFF_W], {OFF_W{1'b0}}};

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.exh   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.tp;
        mem_be    = '1;
        in_ready  = 1'b0;
        out_valid = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st      = ST_EVAL;
                    r_d.base    = tbl_base & ~32'h3;
                    r_d.tp      = tbl_base & ~32'h3;
                    r_d.owed    = xfer_len;
                    r_d.rleft   = '0;
                    r_d.fin     = 1'b0;
                    r_d.raddr   = '0;
                    r_d.dir_mem = to_mem;
                end
            end
            ST_EVAL: begin
                if (r_q.owed == '0) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (r_q.rleft == '0) begin
                    if (r_q.fin || page_out) begin
                        r_d.exh = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.st = ST_DESC_A;
                    end
                end else begin
                    r_d.n  = chunk_n;
                    r_d.k  = '0;
                    r_d.st = r_q.dir_mem ? ST_GATHER : ST_READ;
                end
            end
            ST_DESC_A: begin
                mem_req  = 1'b1;
                mem_addr = r_q.tp;
                if (mem_ack) begin
                    r_d.raddr = mem_rdata;
                    r_d.st    = ST_DESC_S;
                end
            end
            ST_DESC_S: begin
                mem_req  = 1'b1;
                mem_addr = r_q.tp + 32'(WORD_BYTES);
                if (mem_ack) begin
                    r_d.rleft = dec_len;
                    r_d.fin   = dec_fin;
                    r_d.tp    = r_q.tp + 32'(DESC_STRIDE);
                    r_d.st    = ST_EVAL;
                end
            end
            ST_GATHER: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    r_d.data[{lane, 3'b000} +: 8] = in_data;
                    r_d.k = r_q.k + N_W'(1);
                    if (r_q.k + N_W'(1) == r_q.n) begin
                        r_d.st = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = word_addr;
                mem_be   = lane_be;
                if (mem_ack) begin
                    r_d.raddr = r_q.raddr + 32'(r_q.n);
                    r_d.rleft = r_q.rleft - REGION_W'(r_q.n);
                    r_d.owed  = r_q.owed - LEN_W'(r_q.n);
                    r_d.st    = ST_EVAL;
                end
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = word_addr;
                if (mem_ack) begin
                    r_d.data = mem_rdata;
                    r_d.st   = ST_EMIT;
                end
            end
            ST_EMIT: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    r_d.k = r_q.k + N_W'(1);
                    if (r_q.k + N_W'(1) == r_q.n) begin
                        r_d.raddr = r_q.raddr + 32'(r_q.n);
                        r_d.rleft = r_q.rleft - REGION_W'(r_q.n);
                        r_d.owed  = r_q.owed - LEN_W'(r_q.n);
                        r_d.st    = ST_EVAL;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign exhausted = r_q.exh;
    assign mem_wdata = r_q.data;
    assign out_data  = r_q.data[{lane, 3'b000} +: 8];
endmodule

// File: rtl/sgd_chk.sv
module sgd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        exhausted,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        in_ready,
    input logic        out_valid
);
    // R9
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_be) && $stable(mem_wdata)));

    // R9
    write_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be != 4'b0000));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && exhausted));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !in_ready && !out_valid));

    // R8
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R10
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
endmodule

bind sg_dma_engine sgd_chk u_sgd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .exhausted (exhausted),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .in_ready  (in_ready),
    .out_valid (out_valid)
);

// File: tb/tb_sg_dma_engine.sv
module tb_sg_dma_engine;
    localparam int LEN_W = 20;
    localparam int MSZ   = 16384;
    localparam int MASK  = MSZ - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic             start = 1'b0;
    logic [31:0]      tbl_base = '0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic             to_mem = 1'b0;
    logic             busy, done, exhausted;
    logic             mem_req, mem_we;
    logic [31:0]      mem_addr, mem_wdata;
    logic [3:0]       mem_be;
    logic             mem_ack = 1'b0;
    logic [31:0]      mem_rdata = '0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = '0;
    logic             in_ready;
    logic             out_valid;
    logic [7:0]       out_data;
    logic             out_ready = 1'b0;

    sg_dma_engine #(.LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tbl_base(tbl_base),
        .xfer_len(xfer_len), .to_mem(to_mem), .busy(busy), .done(done),
        .exhausted(exhausted), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready)
    );

    logic [7:0] mem [MSZ];
    logic [7:0] exp_mem [MSZ];
    logic [7:0] src [4096];
    logic [7:0] got [$];
    logic [7:0] expq [$];
    int src_len = 0;
    int src_idx = 0;
    int acks = 0;
    int n_chk = 0;
    int n_bad = 0;

    // memory model, stream source and sink, all acting at the falling edge
    always @(negedge clk) begin
        int a;
        a = int'(mem_addr[13:0]);
        if (mem_req && !mem_ack && ($urandom % 3 != 0)) begin
            if (mem_we) begin
                for (int i = 0; i < 4; i++)
                    if (mem_be[i]) mem[(a + i) & MASK] = mem_wdata[8*i +: 8];
            end else begin
                mem_rdata = {mem[(a+3) & MASK], mem[(a+2) & MASK],
                             mem[(a+1) & MASK], mem[a & MASK]};
            end
            mem_ack = 1'b1;
            acks++;
        end else begin
            mem_ack = 1'b0;
        end
        in_valid = (src_idx < src_len) && ($urandom % 4 != 0);
        in_data  = src[src_idx & 4095];
        if (in_valid && in_ready) src_idx++;
        out_ready = ($urandom % 4 != 0);
        if (out_valid && out_ready) got.push_back(out_data);
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic logic [31:0] rd32(input int a);
        return {mem[(a+3) & MASK], mem[(a+2) & MASK], mem[(a+1) & MASK], mem[a & MASK]};
    endfunction

    task automatic put32(input int a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) mem[(a + i) & MASK] = v[8*i +: 8];
    endtask

    task automatic put_desc(input int tbl, input int idx, input logic [31:0] region,
                            input logic [31:0] szw);
        put32(tbl + 8*idx, region);
        put32(tbl + 8*idx + 4, szw);
    endtask

    // reference walk of the table, written from the requirements
    task automatic model(input int base, input int len, input bit tm,
                         output bit exh, output int moved);
        int tp, owed, left, ra, c;
        bit fin;
        logic [31:0] szw;
        tp = base; owed = len; left = 0; fin = 0; ra = 0; moved = 0; exh = 0;
        while (owed > 0) begin
            if (left == 0) begin
                if (fin || (tp - base) >= 4096) begin
                    exh = 1;
                    break;
                end
                ra   = int'(rd32(tp));
                szw  = rd32(tp + 4);
                left = int'(szw[15:1]) * 2;
                if (left == 0) left = 65536;
                fin  = szw[31];
                tp  += 8;
            end else begin
                c = (owed < left) ? owed : left;
                for (int j = 0; j < c; j++) begin
                    if (tm) exp_mem[(ra + j) & MASK] = src[(moved + j) & 4095];
                    else    expq.push_back(mem[(ra + j) & MASK]);
                end
                ra += c; left -= c; owed -= c; moved += c;
            end
        end
    endtask

    task automatic run(input int base, input int len, input bit tm, input string tag);
        bit eexh, gdone, gexh;
        int emoved, cyc, bad, moved;
        for (int i = 0; i < 4096; i++) src[i] = 8'($urandom);
        for (int i = 0; i < MSZ; i++) exp_mem[i] = mem[i];
        expq.delete();
        got.delete();
        model(base, len, tm, eexh, emoved);
        src_idx = 0;
        src_len = tm ? len : 0;
        acks = 0;
        @(negedge clk);
        tbl_base = base; xfer_len = LEN_W'(len); to_mem = tm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        gdone = 0; gexh = 0; cyc = 0;
        while (!gdone && !gexh && cyc < 40000) begin
            @(negedge clk);
            gdone = done; gexh = exhausted; cyc++;
        end
        src_len = 0;
        check(cyc < 40000, {tag, " watchdog"}, cyc, 40000);
        check(gexh == eexh && gdone == !eexh, {tag, " outcome R4 R6 R7"},
              int'(gexh), int'(eexh));
        moved = tm ? src_idx : got.size();
        check(moved == emoved, {tag, " bytes moved R5"}, moved, emoved);
        bad = 0;
        if (tm) begin
            for (int i = 0; i < MSZ; i++) if (mem[i] !== exp_mem[i]) bad++;
        end else begin
            for (int i = 0; i < got.size() && i < expq.size(); i++)
                if (got[i] !== expq[i]) bad++;
        end
        check(bad == 0, {tag, " content R8 R1"}, bad, 0);
    endtask

    initial begin
        void'($urandom(32'h0005_EED1));
        for (int i = 0; i < MSZ; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(!busy && !done && !exhausted && !mem_req && !in_ready && !out_valid,
              "R11 reset state", int'(busy), 0);

        // R7 zero-byte request: done, no memory access
        put_desc(32'h1000, 0, 32'h2000, 32'h8000_0010);
        run(32'h1000, 0, 1'b0, "R7 zero length");
        check(acks == 0, "R7 no access on zero length", acks, 0);

        // R2 bit 0 of size word ignored: 7 -> 6 bytes, then exhausted
        put_desc(32'h1000, 0, 32'h2001, 32'h8000_0007);
        run(32'h1000, 20, 1'b1, "R2 odd size");

        // R3 count field zero means 65536
        put_desc(32'h1000, 0, 32'h2103, 32'h8000_0000);
        put_desc(32'h1000, 1, 32'h3000, 32'h8000_0004);
        run(32'h1000, 300, 1'b1, "R3 zero count");

        // R5 region leftovers, fetch only when region is empty
        put_desc(32'h1100, 0, 32'h2402, 32'h0000_000A);
        put_desc(32'h1100, 1, 32'h2603, 32'h8000_0008);
        run(32'h1100, 5, 1'b0, "R5 partial region");
        run(32'h1100, 15, 1'b1, "R5 span regions");

        // R4 final flag stops the walk even with a valid entry after it
        put_desc(32'h1200, 0, 32'h2701, 32'h8000_0004);
        put_desc(32'h1200, 1, 32'h2800, 32'h8000_0020);
        run(32'h1200, 20, 1'b0, "R4 final flag");

        // R6 4 KiB window: 512 entries of 2 bytes, bait entry just above
        for (int i = 0; i < 512; i++) put_desc(32'h1000, i, 32'h2800 + 2*i, 32'h0000_0002);
        put_desc(32'h2000, 0, 32'h3800, 32'h8000_0064);
        run(32'h1000, 2000, 1'b1, "R6 page limit to memory");
        run(32'h1000, 1500, 1'b0, "R6 page limit to stream");

        // R10 restart walks from the first entry again
        run(32'h1000, 7, 1'b0, "R10 restart");

        // constrained random tables and requests
        for (int t = 0; t < 40; t++) begin
            int nd, tb;
            logic [31:0] szw;
            nd = 1 + int'($urandom % 4);
            tb = 32'h1000 + 4 * int'($urandom % 256);
            for (int d = 0; d < nd; d++) begin
                szw = 32'((($urandom % 21) + 1) * 2) | 32'($urandom % 2);
                if (d == nd - 1) szw[31] = 1'b1;
                put_desc(tb, d, 32'h2000 + ($urandom % 32'h1800), szw);
            end
            run(tb, int'($urandom % 120), t[0], "R5 R8 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule